// File: doc/BRIEF.md
# Extreme-Cell Edge-Delay Voltage Balancer

This block sits between the arm modulator and the cell gate drivers of a multilevel converter arm. Once per carrier period it looks at the measured capacitor voltage of every cell in the arm and picks out the cell with the highest voltage and the cell with the lowest voltage. All other cells pass through untouched. The two extreme cells get one gate edge each postponed by the same number of clock ticks. Which edge is postponed depends on the sign of the arm current. Every change of the output is a copy of a change of the input, so no switching events are created, and the two equal delays cancel in the arm voltage over time.

The size of the postponement comes from a proportional law on the spread between the highest and lowest voltage. The law is re-evaluated once every N carrier periods, where N is the number of cells, and its result is clamped to a fixed fraction of the carrier period. No sorting is done. A single linear scan finds both extremes.

Top module: `arm_extreme_balancer`

## Requirements
- R1: While reset is high and on the first edge after reset, `gate_out` is all zero. The delay value starts at zero and the period counter starts at zero.
- R2: On each clock edge where `period_start` is high, the cell with the largest voltage becomes the "high" cell and the cell with the smallest voltage becomes the "low" cell. Cell k's voltage is `cell_v[k*VW +: VW]`, unsigned. On ties, the lowest index wins for both roles. These roles hold until the next `period_start`.
- R3: When `current_neg` was 0 at the latching edge (zero current counts as positive), every rising edge of the high cell and every falling edge of the low cell reaches `gate_out` D clock cycles later than an undelayed edge.
- R4: When `current_neg` was 1 at the latching edge, the high cell's falling edges and the low cell's rising edges are the ones delayed by D cycles.
- R5: A cell with no role, and every edge that is not selected for delay, appears on `gate_out` exactly one clock after it appears on `gate_in`.
- R6: D is updated on every N-th `period_start` after reset, using the voltages present at that edge. The new value is D = min((spread*KP) >> KSH, DMAX), where spread = vmax - vmin.
- R7: DMAX = PERIOD_TICKS*CAP_PCT/100, which is 10 with the default parameters. D never exceeds DMAX.
- R8: If the spread is zero at a `period_start`, no cell is given a role for that period.
- R9: If the input returns to the output's level before a pending delay expires, the pending change is dropped and the output keeps its level.
- R10: Every change of `gate_out[k]` takes the value that `gate_in[k]` had on the previous clock. The output never changes toward any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; delays are counted in these ticks |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | One-cycle pulse at each carrier period boundary |
| current_neg | input | 1 | Arm current sign, 1 = negative |
| cell_v | input | N*VW | Packed unsigned cell capacitor voltages |
| gate_in | input | N | Gate vector from the modulator |
| gate_out | output | N | Gate vector after edge trimming |

## Verification
The hardest situation to reach is an opposite edge arriving while a delay is still counting. Reaching it needs a large spread held for N periods, so that D first climbs to its cap, and then a pulse narrower than D placed on the high cell. The bench does exactly that, and it also measures the hold length of single edges directly at the ports for both current signs. The delay value is reached through the N-period update cadence, and the bench drives tied and all-equal voltage sets to exercise the role selection.

// File: rtl/bal_pkg.sv
package bal_pkg;

    // Per-cell adjustment selected at each period boundary
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_RISE = 2'd1,
        ADJ_FALL = 2'd2
    } adj_e;

    // Proportional law with right shift and clamp
    function automatic int unsigned p_law(input int unsigned err,
                                          input int unsigned kp,
                                          input int unsigned sh,
                                          input int unsigned lim);
        int unsigned prod;
        prod = (err * kp) >> sh;
        return (prod > lim) ? lim : prod;
    endfunction

    // Role of one cell given the scan result and current sign
    function automatic adj_e pick_role(input logic is_hi,
                                       input logic is_lo,
                                       input logic spread_nz,
                                       input logic neg);
        if (!spread_nz)  return ADJ_NONE;
        if (is_hi)       return neg ? ADJ_FALL : ADJ_RISE;
        if (is_lo)       return neg ? ADJ_RISE : ADJ_FALL;
        return ADJ_NONE;
    endfunction

endpackage

// File: rtl/bal_extreme_scan.sv
module bal_extreme_scan #(
    parameter int N  = 4,
    parameter int VW = 12,
    parameter int IW = 2
) (
    input  logic [N*VW-1:0] cell_v,
    output logic [IW-1:0]   hi_idx,
    output logic [IW-1:0]   lo_idx,
    output logic [VW-1:0]   spread
);
    logic [VW-1:0] vmax, vmin;

    // Single linear pass; strict compares keep the lowest index on ties
    always_comb begin
        vmax   = cell_v[VW-1:0];
        vmin   = cell_v[VW-1:0];
        hi_idx = '0;
        lo_idx = '0;
        for (int k = 1; k < N; k++) begin
            if (cell_v[k*VW +: VW] > vmax) begin
                vmax   = cell_v[k*VW +: VW];
                hi_idx = IW'(k);
            end
            if (cell_v[k*VW +: VW] < vmin) begin
                vmin   = cell_v[k*VW +: VW];
                lo_idx = IW'(k);
            end
        end
        spread = vmax - vmin;
    end
endmodule

// File: rtl/bal_spread_ctrl.sv
module bal_spread_ctrl
    import bal_pkg::*;
#(
    parameter int N    = 4,
    parameter int VW   = 12,
    parameter int DW   = 4,
    parameter int KP   = 1,
    parameter int KSH  = 2,
    parameter int DMAX = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          period_start,
    input  logic [VW-1:0] spread,
    output logic [DW-1:0] delay
);
    localparam int PCW = (N > 1) ? $clog2(N) : 1;

    logic [PCW-1:0] pc_q;
    logic [DW-1:0]  delay_q;
    logic [DW-1:0]  delay_new;

    assign delay_new = DW'(p_law(32'(spread), KP, KSH, DMAX));
    assign delay     = delay_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            delay_q <= '0;
        end else if (period_start) begin
            if (pc_q == PCW'(N - 1)) begin
                pc_q    <= '0;
                delay_q <= delay_new;
            end else begin
                pc_q <= pc_q + PCW'(1);
            end
        end
    end

    // R7
    delay_cap_chk: assert property (@(posedge clk) disable iff (rst)
        delay_q <= DW'(DMAX));

    // R6
    delay_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_start |=> $stable(delay_q));

    // R6
    pc_range_chk: assert property (@(posedge clk) disable iff (rst)
        pc_q <= PCW'(N - 1));
endmodule

// File: rtl/bal_edge_hold.sv
module bal_edge_hold
    import bal_pkg::*;
#(
    parameter int DW   = 4,
    parameter int DMAX = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  adj_e          mode,
    input  logic [DW-1:0] delay,
    input  logic          gin,
    output logic          gout
);
    logic [DW-1:0] cnt_q;
    logic          out_q;
    logic          tgt_edge;

    assign gout     = out_q;
    assign tgt_edge = (mode == ADJ_RISE && gin) || (mode == ADJ_FALL && !gin);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else if (mode == ADJ_NONE) begin
            out_q <= gin;
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            if (gin == out_q) begin
                cnt_q <= '0;                 // input came back: drop change
            end else begin
                cnt_q <= cnt_q - DW'(1);
                if (cnt_q == DW'(1)) out_q <= gin;
            end
        end else if (gin != out_q) begin
            if (tgt_edge && delay != '0) cnt_q <= delay;
            else                         out_q <= gin;
        end
    end

    // R10
    copy_only_chk: assert property (@(posedge clk) disable iff (rst)
        (out_q != $past(out_q)) |-> (out_q == $past(gin)));

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == ADJ_NONE) |=> (out_q == $past(gin)));

    // R7
    hold_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= DW'(DMAX));

    // R9
    drop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != ADJ_NONE && cnt_q != '0 && gin == out_q) |=> (cnt_q == '0 && $stable(out_q)));
endmodule

// File: rtl/arm_extreme_balancer.sv
module arm_extreme_balancer
    import bal_pkg::*;
#(
    parameter int N            = 4,
    parameter int VW           = 12,
    parameter int PERIOD_TICKS = 100,
    parameter int CAP_PCT      = 10,
    parameter int KP           = 1,
    parameter int KSH          = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          period_start,
    input  logic          current_neg,
    input  logic [N*VW-1:0] cell_v,
    input  logic [N-1:0]  gate_in,
    output logic [N-1:0]  gate_out
);
    localparam int DMAX = PERIOD_TICKS * CAP_PCT / 100;
    localparam int DW   = $clog2(DMAX + 1);
    localparam int IW   = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IW-1:0] hi;
        logic [IW-1:0] lo;
        logic [VW-1:0] spread;
    } scan_t;

    scan_t         scan;
    logic [DW-1:0] delay;
    adj_e          mode_q [N];
    logic [N-1:0]  rise_vec, fall_vec;

    bal_extreme_scan #(.N(N), .VW(VW), .IW(IW)) u_scan (
        .cell_v (cell_v),
        .hi_idx (scan.hi),
        .lo_idx (scan.lo),
        .spread (scan.spread)
    );

    bal_spread_ctrl #(.N(N), .VW(VW), .DW(DW), .KP(KP), .KSH(KSH), .DMAX(DMAX)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .period_start (period_start),
        .spread       (scan.spread),
        .delay        (delay)
    );

    generate
        for (genvar k = 0; k < N; k++) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst) begin
                    mode_q[k] <= ADJ_NONE;
                end else if (period_start) begin
                    mode_q[k] <= pick_role(scan.hi == IW'(k), scan.lo == IW'(k),
                                           scan.spread != '0, current_neg);
                end
            end

            assign rise_vec[k] = (mode_q[k] == ADJ_RISE);
            assign fall_vec[k] = (mode_q[k] == ADJ_FALL);

            bal_edge_hold #(.DW(DW), .DMAX(DMAX)) u_hold (
                .clk   (clk),
                .rst   (rst),
                .mode  (mode_q[k]),
                .delay (delay),
                .gin   (gate_in[k]),
                .gout  (gate_out[k])
            );
        end
    endgenerate

    // R2
    one_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rise_vec));

    // R2
    one_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fall_vec));

    // R8
    flat_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (period_start && scan.spread == '0) |=> (rise_vec == '0 && fall_vec == '0));

    // R3
    pair_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rise_vec) == $countones(fall_vec));
endmodule

// File: tb/arm_extreme_balancer_test.sv
module arm_extreme_balancer_test;
    localparam int N    = 4;
    localparam int VW   = 12;
    localparam int PER  = 100;
    localparam int DMAX = 10;
    localparam int KP   = 1;
    localparam int KSH  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ps  = 1'b0;
    logic ineg = 1'b0;
    logic [N*VW-1:0] cell_v = '0;
    logic [N-1:0] gi = '0;
    logic [N-1:0] gate_out;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    int vv [N];
    int rs [N];
    int fl [N];

    // reference model state
    int m_out [N];
    int m_cnt [N];
    int m_mode [N];   // 0 none, 1 delay rise, 2 delay fall
    int m_d  = 0;
    int m_pc = 0;

    arm_extreme_balancer #(.N(N), .VW(VW), .PERIOD_TICKS(PER), .CAP_PCT(10),
                           .KP(KP), .KSH(KSH)) uut (
        .clk(clk), .rst(rst), .period_start(ps), .current_neg(ineg),
        .cell_v(cell_v), .gate_in(gi), .gate_out(gate_out));

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) begin
                m_out[k] = 0; m_cnt[k] = 0; m_mode[k] = 0;
            end
            m_d = 0; m_pc = 0;
        end else begin
            for (int k = 0; k < N; k++) begin
                int g;
                bit tgt;
                g = gi[k];
                tgt = (m_mode[k] == 1 && g == 1) || (m_mode[k] == 2 && g == 0);
                if (m_mode[k] == 0) begin
                    m_out[k] = g; m_cnt[k] = 0;
                end else if (m_cnt[k] > 0) begin
                    if (g == m_out[k]) m_cnt[k] = 0;
                    else begin
                        if (m_cnt[k] == 1) m_out[k] = g;
                        m_cnt[k] = m_cnt[k] - 1;
                    end
                end else if (g != m_out[k]) begin
                    if (tgt && m_d > 0) m_cnt[k] = m_d;
                    else m_out[k] = g;
                end
            end
            if (ps) begin
                int hi, lo, sp;
                hi = 0; lo = 0;
                for (int k = 1; k < N; k++) begin
                    if (vv[k] > vv[hi]) hi = k;
                    if (vv[k] < vv[lo]) lo = k;
                end
                sp = vv[hi] - vv[lo];
                for (int k = 0; k < N; k++) begin
                    m_mode[k] = 0;
                    if (sp != 0 && k == hi) m_mode[k] = ineg ? 2 : 1;
                    else if (sp != 0 && k == lo) m_mode[k] = ineg ? 1 : 2;
                end
                if (m_pc == N - 1) begin
                    m_pc = 0;
                    m_d = (sp * KP) >> KSH;
                    if (m_d > DMAX) m_d = DMAX;
                end else m_pc = m_pc + 1;
            end
        end
    end

    task automatic set_volts(input int a, input int b, input int c, input int d);
        vv[0] = a; vv[1] = b; vv[2] = c; vv[3] = d;
        for (int k = 0; k < N; k++) cell_v[k*VW +: VW] = VW'(vv[k]);
    endtask

    // advance to next falling edge and compare with the model
    task automatic step();
        @(negedge clk);
        checks++;
        for (int k = 0; k < N; k++) begin
            if (int'(gate_out[k]) != m_out[k]) begin
                fails++;
                $display("FAIL %s cell %0d gate_out=%0d expected=%0d at %0t",
                         tag, k, gate_out[k], m_out[k], $time);
                break;
            end
        end
    endtask

    task automatic check_bit(input string req, input int k, input int exp);
        checks++;
        if (int'(gate_out[k]) != exp) begin
            fails++;
            $display("FAIL %s cell %0d gate_out=%0d expected=%0d", req, k, gate_out[k], exp);
        end
    endtask

    task automatic run_periods(input int np);
        for (int p = 0; p < np; p++) begin
            for (int c = 0; c < PER; c++) begin
                ps = (c == 0);
                for (int k = 0; k < N; k++) gi[k] = (c >= rs[k] && c < fl[k]);
                step();
            end
        end
        ps = 1'b0;
    endtask

    task automatic default_pwm();
        for (int k = 0; k < N; k++) begin
            rs[k] = 20 + 5 * k;
            fl[k] = 60 + 3 * k;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        default_pwm();
        set_volts(0, 0, 0, 0);
        // R1: outputs zero under reset even with inputs high
        gi = '1;
        repeat (3) @(negedge clk);
        checks++;
        if (gate_out !== '0) begin
            fails++;
            $display("FAIL R1 gate_out=%b expected=0000", gate_out);
        end
        rst = 1'b0;
        gi = '0;
        step();
        check_bit("R1", 0, 0);

        // R5: no roles yet, pure one-cycle pass-through
        tag = "R5";
        for (int c = 0; c < 12; c++) begin
            gi = N'(c * 5);
            step();
        end
        gi = '0;

        // R3 R6 R7 R10: large spread, cap reached after N boundaries
        tag = "R3 R6 R7 R10";
        set_volts(100, 400, 200, 300);
        ineg = 1'b0;
        run_periods(5);

        // R3: high cell (index 1) rising edge held exactly DMAX extra cycles
        gi = '0;
        repeat (15) step();
        gi[1] = 1'b1;
        repeat (10) step();
        check_bit("R3", 1, 0);
        step();
        check_bit("R3", 1, 1);

        // R4: negative current, high cell falling edge held
        tag = "R4";
        ineg = 1'b1;
        ps = 1'b1;
        step();
        ps = 1'b0;
        repeat (15) step();
        gi[1] = 1'b0;
        repeat (10) step();
        check_bit("R4", 1, 1);
        step();
        check_bit("R4", 1, 0);
        gi = '0;
        repeat (15) step();
        run_periods(3);

        // R6: small spread 10 -> D = 2
        tag = "R6";
        ineg = 1'b0;
        set_volts(200, 210, 205, 208);
        run_periods(5);

        // R8: all equal, no roles and D falls to zero
        tag = "R8";
        set_volts(250, 250, 250, 250);
        run_periods(5);
        gi = '0;
        repeat (5) step();
        gi[2] = 1'b1;
        step();
        check_bit("R8", 2, 1);
        gi = '0;
        step();

        // R2: ties pick the lowest index for both roles
        tag = "R2";
        set_volts(300, 300, 100, 100);
        run_periods(5);

        // R9: pulse shorter than D on the high cell is swallowed
        tag = "R9";
        set_volts(100, 400, 200, 300);
        ineg = 1'b0;
        run_periods(4);
        rs[1] = 30; fl[1] = 34;
        begin
            int highs;
            highs = 0;
            for (int c = 0; c < PER; c++) begin
                ps = (c == 0);
                for (int k = 0; k < N; k++) gi[k] = (c >= rs[k] && c < fl[k]);
                step();
                if (gate_out[1]) highs++;
            end
            ps = 1'b0;
            checks++;
            if (highs != 0) begin
                fails++;
                $display("FAIL R9 high cycles=%0d expected=0", highs);
            end
        end
        default_pwm();
        run_periods(1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule